// File: doc/BRIEF.md
# Heartbeat Interval Timer

A free-running 24-bit down-counter that produces a periodic interrupt for system housekeeping. Software loads a reload value one byte at a time. It then picks how the interrupt is presented and starts the count. The counter steps down once per clock. When it reaches zero it signals a terminal count and reloads itself, so the interval is the reload value plus one clock.

The active-low interrupt line has two presentations. In edge mode, every terminal count gives a fixed two-cycle low pulse, which suits edge-triggered controllers. In level mode, the line goes low at a terminal count and stays low until software writes an acknowledge command, which suits level-sensitive controllers.

All control goes through one command byte. Its low nibble carries a command code, and each command alters exactly one setting. The run flag in the same byte is only taken when the command code is zero, so a command write never disturbs the run state by accident.

Top module: `hb_interval_timer`

## Requirements
- R1: After reset, irq_n is high, the run flag is clear, the interrupt mode is off and the reload value is zero.
- R2: A reload write with rld_sel 0, 1 or 2 replaces reload bits 7:0, 15:8 or 23:16 respectively. A write with rld_sel 3 changes nothing.
- R3: While running, the counter decrements once per clock. A clock that starts at zero is a terminal count and loads the reload value. While stopped, the counter tracks the reload value. The first terminal count therefore ends reload+1 clocks after the clock that sets the run flag, and later ones follow every reload+1 clocks. A reload of zero gives a terminal count on every clock.
- R4: In edge mode, irq_n goes low at the clock following a terminal count and stays low for exactly two clocks. If terminal counts occur back to back, the line stays low continuously.
- R5: In level mode, irq_n goes low at the clock following a terminal count and stays low until an acknowledge command (code 1) is taken. In edge or off mode, an acknowledge has no effect.
- R6: An acknowledge taken in the same clock as a terminal count in level mode leaves irq_n low.
- R7: A terminal count that arrives while a level interrupt is pending keeps irq_n low without any high glitch.
- R8: Command code 3 turns interrupts off, and irq_n is high from the next clock. Code 2 selects level mode and code 4 selects edge mode. Each of these mode commands also clears any pending low.
- R9: The command code occupies cmd_data bits 3:0 and the run flag is bit 4. Bit 4 is stored only when bits 3:0 are zero. Codes 5 to 15 change nothing, but they still block the run flag update. Bits 7:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rld_we | input | 1 | Reload byte write strobe |
| rld_sel | input | 2 | Reload byte index |
| rld_data | input | 8 | Reload byte value |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte (code in 3:0, run flag in 4) |
| irq_n | output | 1 | Active-low timer interrupt |

## Verification
The interesting overlap is a software acknowledge landing in the same clock as a terminal count while level mode is active. The bench sets up this overlap deliberately: with a reload of three, it issues the acknowledge exactly when the counter sits at zero, and it expects the line to remain low. It then checks that a second acknowledge, issued away from any terminal count, releases the line. The same overlap is pushed to its limit with a reload of zero, where every clock is a terminal count and no acknowledge may ever raise the line.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_EDGE  = 2'd1,
        IRQ_LEVEL = 2'd2
    } irq_mode_e;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_NONE  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_ACK   = 4'd1;
    localparam logic [CODE_W-1:0] CODE_LEVEL = 4'd2;
    localparam logic [CODE_W-1:0] CODE_OFF   = 4'd3;
    localparam logic [CODE_W-1:0] CODE_EDGE  = 4'd4;

endpackage

// File: rtl/hbt_reload_reg.sv
module hbt_reload_reg #(
    parameter int CNT_W  = 24,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] data,
    output logic [CNT_W-1:0]  reload
);
    localparam int NUM_BYTES = (CNT_W + BYTE_W - 1) / BYTE_W;
    localparam int REG_W     = NUM_BYTES * BYTE_W;

    typedef struct packed {
        logic [REG_W-1:0] val;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (we && sel == SEL_W'(b)) begin
                s_d.val[b*BYTE_W +: BYTE_W] = data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reload = s_q.val[CNT_W-1:0];
endmodule

// File: rtl/hbt_counter.sv
module hbt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             tc
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    assign tc = run && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (!run || tc) s_d.cnt = reload;
        else            s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/hbt_cmd_dec.sv
module hbt_cmd_dec #(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] data,
    output logic              run,
    output logic              ack_go,
    output logic              off_go,
    output logic              edge_go,
    output logic              level_go
);
    import hbt_pkg::*;

    localparam int RUN_BIT = CODE_W;

    typedef struct packed {
        logic run;
    } state_t;

    state_t s_d, s_q;
    logic [CODE_W-1:0] code;

    assign code = data[CODE_W-1:0];

    always_comb begin
        s_d = s_q;
        if (we && code == CODE_NONE) s_d.run = data[RUN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run      = s_q.run;
    assign ack_go   = we && (code == CODE_ACK);
    assign off_go   = we && (code == CODE_OFF);
    assign edge_go  = we && (code == CODE_EDGE);
    assign level_go = we && (code == CODE_LEVEL);
endmodule

// File: rtl/hbt_irq_gen.sv
module hbt_irq_gen #(
    parameter int PULSE_LEN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tc,
    input  logic                 ack_go,
    input  logic                 off_go,
    input  logic                 edge_go,
    input  logic                 level_go,
    output hbt_pkg::irq_mode_e   mode,
    output logic                 irq_n
);
    import hbt_pkg::*;

    localparam int LEFT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        irq_mode_e         mode;
        logic              low;
        logic [LEFT_W-1:0] left;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (off_go) begin
            s_d.mode = IRQ_OFF;
            s_d.low  = 1'b0;
            s_d.left = '0;
        end else if (edge_go || level_go) begin
            s_d.mode = edge_go ? IRQ_EDGE : IRQ_LEVEL;
            s_d.low  = 1'b0;
            s_d.left = '0;
        end else begin
            unique case (s_q.mode)
                IRQ_EDGE: begin
                    if (tc) begin
                        s_d.low  = 1'b1;
                        s_d.left = LEFT_W'(PULSE_LEN - 1);
                    end else if (s_q.left != '0) begin
                        s_d.low  = 1'b1;
                        s_d.left = s_q.left - 1'b1;
                    end else begin
                        s_d.low  = 1'b0;
                    end
                end
                IRQ_LEVEL: begin
                    if (tc)          s_d.low = 1'b1;
                    else if (ack_go) s_d.low = 1'b0;
                end
                default: begin
                    s_d.low  = 1'b0;
                    s_d.left = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: IRQ_OFF, low: 1'b0, left: '0};
        else        s_q <= s_d;
    end

    assign mode  = s_q.mode;
    assign irq_n = ~s_q.low;
endmodule

// File: rtl/hb_interval_timer.sv
module hb_interval_timer #(
    parameter int CNT_W     = 24,
    parameter int BYTE_W    = 8,
    parameter int SEL_W     = 2,
    parameter int CTRL_W    = 8,
    parameter int PULSE_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rld_we,
    input  logic [SEL_W-1:0]  rld_sel,
    input  logic [BYTE_W-1:0] rld_data,
    input  logic              cmd_we,
    input  logic [CTRL_W-1:0] cmd_data,
    output logic              irq_n
);
    import hbt_pkg::*;

    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_val;
    logic             run_flag;
    logic             term_cnt;
    logic             ack_go, off_go, edge_go, level_go;
    irq_mode_e        irq_mode;

    hbt_reload_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_reload (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rld_we),
        .sel    (rld_sel),
        .data   (rld_data),
        .reload (reload_val)
    );

    hbt_cmd_dec #(.CTRL_W(CTRL_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cmd_we),
        .data     (cmd_data),
        .run      (run_flag),
        .ack_go   (ack_go),
        .off_go   (off_go),
        .edge_go  (edge_go),
        .level_go (level_go)
    );

    hbt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_flag),
        .reload (reload_val),
        .cnt    (cnt_val),
        .tc     (term_cnt)
    );

    hbt_irq_gen #(.PULSE_LEN(PULSE_LEN)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc       (term_cnt),
        .ack_go   (ack_go),
        .off_go   (off_go),
        .edge_go  (edge_go),
        .level_go (level_go),
        .mode     (irq_mode),
        .irq_n    (irq_n)
    );
endmodule

// File: rtl/hbt_checker.sv
module hbt_checker #(
    parameter int CNT_W  = 24,
    parameter int SEL_W  = 2,
    parameter int CTRL_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rld_we,
    input logic [SEL_W-1:0]   rld_sel,
    input logic               cmd_we,
    input logic [CTRL_W-1:0]  cmd_data,
    input logic               irq_n,
    input hbt_pkg::irq_mode_e mode,
    input logic               tc,
    input logic               ack_go,
    input logic               run,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   reload
);
    import hbt_pkg::*;

    // R2
    sel3_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_we && rld_sel == SEL_W'(3)) |=> $stable(reload));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (!run || cnt == $past(cnt) - 1'b1));

    // R4
    edge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == IRQ_EDGE && $fell(irq_n) && !cmd_we) |=> !irq_n);

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == IRQ_LEVEL && !irq_n && !cmd_we) |=> !irq_n);

    // R6
    ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == IRQ_LEVEL && tc && ack_go) |=> !irq_n);

    // R8
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[CODE_W-1:0] == CODE_OFF) |=> irq_n);

    // R9
    run_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[CODE_W-1:0] != CODE_NONE) |=> $stable(run));
endmodule

bind hb_interval_timer hbt_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W), .CTRL_W(CTRL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rld_we   (rld_we),
    .rld_sel  (rld_sel),
    .cmd_we   (cmd_we),
    .cmd_data (cmd_data),
    .irq_n    (irq_n),
    .mode     (irq_mode),
    .tc       (term_cnt),
    .ack_go   (ack_go),
    .run      (run_flag),
    .cnt      (cnt_val),
    .reload   (reload_val)
);

// File: tb/hb_interval_timer_tb.sv
`timescale 1ns/1ps
module hb_interval_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rld_we = 1'b0;
    logic [1:0] rld_sel = '0;
    logic [7:0] rld_data = '0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_data = '0;
    logic       irq_n;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    hb_interval_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rld_we   (rld_we),
        .rld_sel  (rld_sel),
        .rld_data (rld_data),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .irq_n    (irq_n)
    );

    // row: {cmd_we, rld_we, sel[1:0], data[7:0], expected irq_n}
    localparam int NV = 30;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd0, 8'h03, 1'b1},  // R2 byte0 = 3
        {1'b0, 1'b1, 2'd1, 8'h00, 1'b1},
        {1'b0, 1'b1, 2'd2, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd0, 8'h04, 1'b1},  // R8 edge mode
        {1'b1, 1'b0, 2'd0, 8'h10, 1'b1},  // R9 run on
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},  // R3
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},  // R4 pulse
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},  // R3 period 4
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd0, 8'h02, 1'b1},  // R8 level mode
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},  // R5
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},
        {1'b1, 1'b0, 2'd0, 8'h01, 1'b1},  // R5 ack
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},
        {1'b1, 1'b0, 2'd0, 8'h01, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},
        {1'b1, 1'b0, 2'd0, 8'h01, 1'b0},  // R6 ack meets tc
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b0},
        {1'b1, 1'b0, 2'd0, 8'h01, 1'b1},
        {1'b1, 1'b0, 2'd0, 8'h03, 1'b1},  // R8 off
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1},  // R8 tc while off
        {1'b0, 1'b0, 2'd0, 8'h00, 1'b1}
    };

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic cw, input logic rw, input logic [1:0] s, input logic [7:0] d);
        cmd_we = cw; rld_we = rw; rld_sel = s; rld_data = d; cmd_data = d;
        @(posedge clk); #1;
        cmd_we = 1'b0; rld_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1", irq_n, 1'b1);
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][12], VEC[i][11], VEC[i][10:9], VEC[i][8:1]);
            check($sformatf("R3/R4/R5/R6/R8 row %0d", i), irq_n, VEC[i][0]);
        end

        // R1: reset while running clears everything
        cyc(1'b1, 1'b0, 2'd0, 8'h04);
        do_reset();
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 2'd0, 8'h00);
            check("R1", irq_n, 1'b1);
        end

        // R2: select 3 must not touch reload (reload 2)
        cyc(1'b0, 1'b1, 2'd0, 8'h02);
        cyc(1'b0, 1'b1, 2'd3, 8'hFF);
        cyc(1'b1, 1'b0, 2'd0, 8'h04);
        cyc(1'b1, 1'b0, 2'd0, 8'h10);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        check("R2", irq_n, 1'b1);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        check("R2", irq_n, 1'b1);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        check("R2", irq_n, 1'b0);

        // R9: nonzero code blocks run flag; reload zero after reset
        do_reset();
        cyc(1'b1, 1'b0, 2'd0, 8'h14);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 2'd0, 8'h00);
            check("R9", irq_n, 1'b1);
        end
        cyc(1'b1, 1'b0, 2'd0, 8'hFE);
        check("R9", irq_n, 1'b1);
        cyc(1'b1, 1'b0, 2'd0, 8'hF0);
        check("R9", irq_n, 1'b1);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        check("R9", irq_n, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 2'd0, 8'h00);
            check("R3 reload zero", irq_n, 1'b0);
        end

        // R6/R7: level mode with a terminal count every clock
        cyc(1'b1, 1'b0, 2'd0, 8'h02);
        check("R8", irq_n, 1'b1);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        check("R7", irq_n, 1'b0);
        cyc(1'b1, 1'b0, 2'd0, 8'h01);
        check("R6", irq_n, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 2'd0, 8'h00);
            check("R7", irq_n, 1'b0);
        end
        cyc(1'b1, 1'b0, 2'd0, 8'h03);
        check("R8", irq_n, 1'b1);
        cyc(1'b0, 1'b0, 2'd0, 8'h00);
        check("R8", irq_n, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: irq_n=%b expected finish", irq_n);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule